// File: doc/BRIEF.md
# System Control Register with Done Handshake

This block is the 8-bit system control register of a small microcontroller. Software reads and writes it through a plain CPU register port. It holds four live fields. A password-lock flag guards the loader utilities. A ROM-operation-done flag handshakes with a debug control unit. A code-page select maps program memory into data space. A test-port enable gates the test pin functions. The remaining positions are hard zeros.

The done flag sets a small sequence in motion. Software writes 1 to it. If the external JTAG special-purpose flag is set at that moment, the block raises a one-cycle internal system reset request and a one-cycle clear for that external flag. The done flag then stays set until the control unit acknowledges it, and hardware clears it at that point.

The two reset inputs treat the register differently. A power-on reset re-arms the password lock. A general reset restores every other field and leaves the lock as it was.

Top module: `sys_ctl_reg`

## Requirements
- R1: While either reset is asserted (porRst_n or sysRst_n low), bit 7 reads 1 and bits 6, 5, 4, 3, 2 and 0 read 0.
- R2: Power-on reset (porRst_n low) forces bit 1 (password lock) to 1. General reset (sysRst_n low with porRst_n high) leaves bit 1 unchanged. A CPU write sets bit 1 to the written value.
- R3: Bits 0, 3, 5 and 6 always read 0, whatever was written.
- R4: A CPU write (cpuWrEn high at a clock edge) loads bits 7, 4 and 1 from cpuWrData. Without a write, these bits hold their value.
- R5: A write with cpuWrData[2]=1 sets bit 2 (done). If jtagSpeFlag is high at that edge, sysRstReq is high for exactly the following cycle. Otherwise sysRstReq stays low.
- R6: The same write pulses jtagSpeClr high for the following cycle only if jtagSpeFlag is high at that edge.
- R7: cuAck high at an edge clears bit 2. A write with cpuWrData[2]=0 does not change bit 2.
- R8: If cuAck and a write with cpuWrData[2]=1 coincide, bit 2 is 1 after the edge.
- R9: pageMap[0] means page P0 is mapped and pageMap[1] means page P1 is mapped. In word mode (wordMode=1), pageMap is 2'b11. In byte mode, pageMap is 2'b01 when bit 4 is 0 and 2'b10 when bit 4 is 1.
- R10: tapPinEn equals bit 7, pwLock equals bit 1, and romDone equals bit 2 of the register.
- R11: cpuRdData shows the live register contents combinationally, in the same cycle, with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst_n | input | 1 | Power-on reset, asynchronous, active low |
| sysRst_n | input | 1 | General reset, asynchronous, active low |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | Live register contents |
| jtagSpeFlag | input | 1 | External JTAG special-purpose flag |
| jtagSpeClr | output | 1 | One-cycle clear request for that flag |
| cuAck | input | 1 | Control-unit acknowledge of done |
| wordMode | input | 1 | 1 selects word-mode data access |
| sysRstReq | output | 1 | One-cycle internal system reset request |
| pageMap | output | 2 | Mapped code pages, bit 0 = P0, bit 1 = P1 |
| pwLock | output | 1 | Password lock state |
| romDone | output | 1 | ROM-operation-done indication |
| tapPinEn | output | 1 | Test-port pin function enable |

## Verification
The bench builds the block with its default parameters, which fix the 8-bit layout and the positions of the bit fields. The layout is fixed, so the exposure comes from stimulus rather than from sizing. Random streams of writes, acknowledges, flag values and mode changes reach every combination of write, acknowledge and flag in the same cycle, including the case where a write collides with an acknowledge. Directed sequences then alternate the two reset types around a cleared password lock, to separate the two reset paths.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
  localparam int REG_W   = 8;
  localparam int TAP_BIT = 7;
  localparam int CDA_BIT = 4;
  localparam int ROD_BIT = 2;
  localparam int PWL_BIT = 1;

  typedef struct packed {
    logic wrReg;    // load writable fields
    logic setDone;  // write of 1 to done bit
    logic clrDone;  // acknowledge clears done
  } ctlStrobe_t;
endpackage

// File: rtl/sys_ctl_ctrl.sv
module sys_ctl_ctrl
  import sys_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       porRst_n,
  input  logic       sysRst_n,
  input  logic       cpuWrEn,
  input  logic       wrDoneBit,
  input  logic       jtagSpeFlag,
  input  logic       cuAck,
  output ctlStrobe_t strobe,
  output logic       sysRstReq,
  output logic       jtagSpeClr
);
  logic doneWrite;
  logic launch;

  assign doneWrite = cpuWrEn && wrDoneBit;
  assign launch    = doneWrite && jtagSpeFlag;

  always_comb begin
    strobe.wrReg   = cpuWrEn;
    strobe.setDone = doneWrite;
    strobe.clrDone = cuAck && !doneWrite;  // write wins over acknowledge
  end

  // registered pulses, so the reset request never glitches combinationally
  always_ff @(posedge clk or negedge porRst_n or negedge sysRst_n) begin
    if (!porRst_n || !sysRst_n) begin
      sysRstReq  <= 1'b0;
      jtagSpeClr <= 1'b0;
    end else begin
      sysRstReq  <= launch;
      jtagSpeClr <= launch;
    end
  end

  a_r5_req_after_flagged_write: assert property (@(posedge clk)
    disable iff (!porRst_n || !sysRst_n)
    (cpuWrEn && wrDoneBit && jtagSpeFlag) |=> sysRstReq);

  a_r5_req_needs_flag: assert property (@(posedge clk)
    disable iff (!porRst_n || !sysRst_n)
    (cpuWrEn && wrDoneBit && !jtagSpeFlag) |=> !sysRstReq);

  a_r6_clr_only_with_flag: assert property (@(posedge clk)
    disable iff (!porRst_n || !sysRst_n)
    !(cpuWrEn && wrDoneBit && jtagSpeFlag) |=> !jtagSpeClr);
endmodule

// File: rtl/sys_ctl_dp.sv
module sys_ctl_dp
  import sys_ctl_pkg::*;
#(
  parameter logic TAP_RST = 1'b1
) (
  input  logic             clk,
  input  logic             porRst_n,
  input  logic             sysRst_n,
  input  ctlStrobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic             wordMode,
  output logic [REG_W-1:0] rdData,
  output logic [1:0]       pageMap,
  output logic             pwLock,
  output logic             romDone,
  output logic             tapPinEn
);
  logic tapQ, cdaQ, rodQ, pwlQ;

  // password lock: re-armed by power-on reset only
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n)         pwlQ <= 1'b1;
    else if (!sysRst_n)    pwlQ <= pwlQ;
    else if (strobe.wrReg) pwlQ <= wrData[PWL_BIT];
  end

  always_ff @(posedge clk or negedge porRst_n or negedge sysRst_n) begin
    if (!porRst_n || !sysRst_n) begin
      tapQ <= TAP_RST;
      cdaQ <= 1'b0;
      rodQ <= 1'b0;
    end else begin
      if (strobe.wrReg) begin
        tapQ <= wrData[TAP_BIT];
        cdaQ <= wrData[CDA_BIT];
      end
      if (strobe.setDone)      rodQ <= 1'b1;
      else if (strobe.clrDone) rodQ <= 1'b0;
    end
  end

  always_comb begin
    rdData          = '0;
    rdData[TAP_BIT] = tapQ;
    rdData[CDA_BIT] = cdaQ;
    rdData[ROD_BIT] = rodQ;
    rdData[PWL_BIT] = pwlQ;
  end

  always_comb begin
    if (wordMode)  pageMap = 2'b11;
    else if (cdaQ) pageMap = 2'b10;
    else           pageMap = 2'b01;
  end

  assign pwLock   = pwlQ;
  assign romDone  = rodQ;
  assign tapPinEn = tapQ;

  a_r4_pwl_holds_without_write: assert property (@(posedge clk)
    disable iff (!porRst_n || !sysRst_n)
    !strobe.wrReg |=> $stable(pwlQ));

  a_r7_ack_clears_done: assert property (@(posedge clk)
    disable iff (!porRst_n || !sysRst_n)
    (strobe.clrDone && !strobe.setDone) |=> !rodQ);

  a_r8_write_beats_ack: assert property (@(posedge clk)
    disable iff (!porRst_n || !sysRst_n)
    strobe.setDone |=> rodQ);

  a_r3_reserved_zero: assert property (@(posedge clk)
    disable iff (!porRst_n || !sysRst_n)
    strobe.wrReg |=> (rdData[6:5] == 2'b00 && rdData[3] == 1'b0 && rdData[0] == 1'b0));
endmodule

// File: rtl/sys_ctl_reg.sv
module sys_ctl_reg
  import sys_ctl_pkg::*;
#(
  parameter logic TAP_RST = 1'b1
) (
  input  logic       clk,
  input  logic       porRst_n,
  input  logic       sysRst_n,
  input  logic       cpuWrEn,
  input  logic [7:0] cpuWrData,
  output logic [7:0] cpuRdData,
  input  logic       jtagSpeFlag,
  output logic       jtagSpeClr,
  input  logic       cuAck,
  input  logic       wordMode,
  output logic       sysRstReq,
  output logic [1:0] pageMap,
  output logic       pwLock,
  output logic       romDone,
  output logic       tapPinEn
);
  ctlStrobe_t strobe;

  sys_ctl_ctrl u_ctrl (
    .clk        (clk),
    .porRst_n   (porRst_n),
    .sysRst_n   (sysRst_n),
    .cpuWrEn    (cpuWrEn),
    .wrDoneBit  (cpuWrData[ROD_BIT]),
    .jtagSpeFlag(jtagSpeFlag),
    .cuAck      (cuAck),
    .strobe     (strobe),
    .sysRstReq  (sysRstReq),
    .jtagSpeClr (jtagSpeClr)
  );

  sys_ctl_dp #(.TAP_RST(TAP_RST)) u_dp (
    .clk      (clk),
    .porRst_n (porRst_n),
    .sysRst_n (sysRst_n),
    .strobe   (strobe),
    .wrData   (cpuWrData),
    .wordMode (wordMode),
    .rdData   (cpuRdData),
    .pageMap  (pageMap),
    .pwLock   (pwLock),
    .romDone  (romDone),
    .tapPinEn (tapPinEn)
  );
endmodule

// File: tb/sys_ctl_reg_bench.sv
`timescale 1ns/1ps
module sys_ctl_reg_bench;
  logic       clk = 1'b0;
  logic       porRst_n = 1'b0, sysRst_n = 1'b1;
  logic       cpuWrEn = 1'b0, jtagSpeFlag = 1'b0, cuAck = 1'b0, wordMode = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic       jtagSpeClr, sysRstReq, pwLock, romDone, tapPinEn;
  logic [1:0] pageMap;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // bench model of the register
  logic mTap, mCda, mRod, mPwl, mReq;

  always #4 clk = ~clk;

  sys_ctl_reg u_sys_ctl_reg (
    .clk(clk), .porRst_n(porRst_n), .sysRst_n(sysRst_n),
    .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .jtagSpeFlag(jtagSpeFlag), .jtagSpeClr(jtagSpeClr), .cuAck(cuAck),
    .wordMode(wordMode), .sysRstReq(sysRstReq), .pageMap(pageMap),
    .pwLock(pwLock), .romDone(romDone), .tapPinEn(tapPinEn)
  );

  function automatic logic [7:0] expRd();
    return {mTap, 2'b00, mCda, 1'b0, mRod, mPwl, 1'b0};
  endfunction

  function automatic logic [1:0] expMap(input logic wm, input logic cda);
    return wm ? 2'b11 : (cda ? 2'b10 : 2'b01);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " R3/R11 readback"}, cpuRdData, expRd());
    check({tag, " R5 sysRstReq"}, {7'd0, sysRstReq}, {7'd0, mReq});
    check({tag, " R6 jtagSpeClr"}, {7'd0, jtagSpeClr}, {7'd0, mReq});
    check({tag, " R9 pageMap"}, {6'd0, pageMap}, {6'd0, expMap(wordMode, mCda)});
    check({tag, " R10 pins"}, {5'd0, tapPinEn, pwLock, romDone}, {5'd0, mTap, mPwl, mRod});
  endtask

  // one clock step: inputs set at negedge, results compared at next negedge
  task automatic step(input logic wr, input logic [7:0] d, input logic ack,
                      input logic flag, input logic wm);
    cpuWrEn = wr; cpuWrData = d; cuAck = ack; jtagSpeFlag = flag; wordMode = wm;
    mReq = wr && d[2] && flag;
    if (wr) begin mTap = d[7]; mCda = d[4]; mPwl = d[1]; end
    if (wr && d[2]) mRod = 1'b1;
    else if (ack)   mRod = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cpuWrEn = 1'b0; cuAck = 1'b0;
  endtask

  task automatic applyReset(input bit por);
    @(negedge clk);
    if (por) porRst_n = 1'b0; else sysRst_n = 1'b0;
    #1;
    mTap = 1; mCda = 0; mRod = 0; mReq = 0;
    if (por) mPwl = 1;
    check(por ? "R1/R2 por value" : "R1/R2 sys value", cpuRdData, expRd());
    @(negedge clk);
    porRst_n = 1'b1; sysRst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mTap = 1; mCda = 0; mRod = 0; mPwl = 1; mReq = 0;
    @(negedge clk);
    check("R1 power-on read 0x82", cpuRdData, 8'h82);
    porRst_n = 1'b1;
    @(negedge clk);
    checkAll("after por");

    // R2: clear lock, general reset keeps it cleared
    step(1, 8'h00, 0, 0, 0);
    check("R4 write 0x00", cpuRdData, 8'h00);
    check("R10 tap off", {7'd0, tapPinEn}, 8'd0);
    applyReset(0);
    check("R2 sys reset keeps lock 0", cpuRdData, 8'h80);
    step(1, 8'hFF, 0, 0, 0);
    check("R3 reserved ignore ones", cpuRdData, 8'h96);
    applyReset(1);
    check("R2 por re-arms lock", cpuRdData, 8'h82);

    // R5/R6: flagged done write
    step(1, 8'h84, 0, 1, 0);
    checkAll("R5 flagged write");
    step(0, 8'h00, 0, 1, 0);
    check("R5 pulse single cycle", {7'd0, sysRstReq}, 8'd0);
    // R7: write 0 to done does not clear, ack does
    step(1, 8'h80, 0, 0, 0);
    check("R7 write 0 keeps done", {7'd0, romDone}, 8'd1);
    step(0, 8'h00, 1, 0, 0);
    check("R7 ack clears done", {7'd0, romDone}, 8'd0);
    // R8: collision
    step(1, 8'h84, 1, 0, 0);
    check("R8 write beats ack", {7'd0, romDone}, 8'd1);
    check("R5 no req without flag", {7'd0, sysRstReq}, 8'd0);
    // R9 modes
    step(1, 8'h90, 0, 0, 0);
    check("R9 byte P1", {6'd0, pageMap}, 8'h02);
    step(0, 8'h00, 0, 0, 1);
    check("R9 word both", {6'd0, pageMap}, 8'h03);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[15:8], r[1] & r[2], r[3], r[4]);
      checkAll("random");
    end
    applyReset(0);
    checkAll("final sys reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule